// File: doc/BRIEF.md
# Boot Vector Sequencer

This block brings an 8-bit processor core out of reset. Once the synchronous active-low reset is released, it walks through a fixed, cycle-exact schedule. First it writes the reset values of the status register, the stack pointer and the two working registers through a single register-write port. It then fetches a two-byte start vector from two fixed memory addresses over a synchronous read port, reading the higher address first. It combines the two returned bytes into the program counter and finally issues the first opcode fetch from that address.

The memory answers one cycle after the read strobe. The sequencer takes each byte on that return cycle and passes it straight to the register-write port as the matching program-counter half. Idle cycles fill the remaining time, so the fetch always lands on the same cycle after release.

Cycle numbering used below: cycle n is the clock period that follows the n-th rising edge at which `rst_n` is sampled high after a reset.

Top module: `boot_vector_seq`

## Requirements
- R1: In every cycle that follows an edge at which `rst_n` was sampled low, `mem_rd`, `rf_we` and `fetch_start` are all low.
- R2: In cycle 1 the port writes 00h with `rf_sel`=0 (status register). In cycle 2 it writes 01h with `rf_sel`=1 (stack pointer).
- R3: In cycle 3 it writes 00h with `rf_sel`=2 (register A), and in cycle 4 it writes 00h with `rf_sel`=3 (register B). `rf_we` is low in every cycle up to 20 other than 1, 2, 3, 4, 6 and 8, so no other storage is written.
- R4: `mem_rd` is high with `mem_addr`=07FFh in cycle 5 and with `mem_addr`=07FEh in cycle 7. It is low in all other cycles before cycle 20.
- R5: In cycle 6 the port writes the byte on `mem_rdata` with `rf_sel`=4 (PC low byte). In cycle 8 it writes the byte on `mem_rdata` with `rf_sel`=5 (PC high byte). The low byte is therefore taken before the high byte.
- R6: `fetch_start` is high in cycle 20 and in no other cycle. In that cycle `mem_rd` is high and `mem_addr` equals the high byte (bits 15:8) joined to the low byte (bits 7:0) returned in cycles 6 and 8.
- R7: After cycle 20, `mem_rd`, `rf_we` and `fetch_start` stay low until the next reset.
- R8: A reset asserted at any point of the schedule abandons it. After the next release the whole schedule runs again from cycle 1, using only the vector bytes read in the new run.
- R9: The value of `mem_rdata` in any cycle other than 6 and 8 has no effect on the register writes or on the fetch address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address, valid while `mem_rd` is high |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| rf_we | output | 1 | Register write enable |
| rf_sel | output | 3 | Register target: 0 status, 1 stack pointer, 2 A, 3 B, 4 PC low, 5 PC high |
| rf_wdata | output | 8 | Register write data |
| fetch_start | output | 1 | One-cycle first opcode fetch marker |

## Verification
The schedule runs under a sweep of 256 vector byte pairs, with the low and high bytes varied independently. This shows whether the two bytes are swapped, mixed up, or taken from the wrong return cycle. On every cycle without a memory return, the read-data input carries a shifting pseudo-random pattern, which shows whether any stray capture happens. A second sweep cuts the schedule off with a new reset after every possible cycle count and then restarts it with different vector bytes. This separates a true restart from a resumed count or from bytes left over from the aborted run. Every cycle of every run is compared with the schedule, including the quiet cycles after the fetch.

// File: rtl/bvs_pkg.sv
// Shared types and schedule step numbers for the boot vector sequencer.
// Assumes the fixed steps all complete before the fetch cycle.
package bvs_pkg;

    // Register targets on the write port; the values are visible at the port.
    typedef enum logic [2:0] {
        RF_ST  = 3'd0,
        RF_SP  = 3'd1,
        RF_A   = 3'd2,
        RF_B   = 3'd3,
        RF_PCL = 3'd4,
        RF_PCH = 3'd5
    } rf_sel_e;

    // Source of the register write data.
    typedef enum logic [1:0] {
        WSRC_ZERO = 2'd0,
        WSRC_ST   = 2'd1,
        WSRC_SP   = 2'd2,
        WSRC_MEM  = 2'd3
    } wsrc_e;

    // Source of the memory address.
    typedef enum logic [1:0] {
        ASEL_VLO = 2'd0,
        ASEL_VHI = 2'd1,
        ASEL_PC  = 2'd2
    } asel_e;

    // Per-cycle control word produced by the step decoder.
    typedef struct packed {
        logic    rf_we;
        rf_sel_e rf_sel;
        wsrc_e   wsrc;
        logic    rd;
        asel_e   asel;
        logic    cap_lo;
        logic    cap_hi;
        logic    fetch;
    } step_ctl_t;

    // Cycle numbers of the fixed steps after reset release.
    localparam int STEP_ST     = 1;
    localparam int STEP_SP     = 2;
    localparam int STEP_A      = 3;
    localparam int STEP_B      = 4;
    localparam int STEP_RD_LO  = 5;
    localparam int STEP_CAP_LO = 6;
    localparam int STEP_RD_HI  = 7;
    localparam int STEP_CAP_HI = 8;
    localparam int STEP_LAST   = STEP_CAP_HI;

endpackage

// File: rtl/bvs_step_timer.sv
// Cycle counter for the boot schedule. It holds zero while reset is asserted,
// counts one per clock after release and stops one past the fetch cycle.
// Assumes START_CYCLES exceeds the last fixed step.
module bvs_step_timer #(
    parameter int START_CYCLES = 20,
    parameter int CNT_W        = $clog2(START_CYCLES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] DONE_VAL = CNT_W'(START_CYCLES + 1);

    // Advance the step count until the terminal value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != DONE_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: a fresh release always starts from step zero.
    p_release_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0));

    // R7: once terminal, the count never moves again without a reset.
    p_hold_terminal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == DONE_VAL) |=> (cnt == DONE_VAL));

endmodule

// File: rtl/bvs_step_decode.sv
// Decodes the step count into the control word for one cycle.
// Purely combinational; assumes START_CYCLES lies beyond STEP_LAST.
module bvs_step_decode
    import bvs_pkg::*;
#(
    parameter int START_CYCLES = 20,
    parameter int CNT_W        = $clog2(START_CYCLES + 2)
) (
    input  logic [CNT_W-1:0] cnt,
    output step_ctl_t        ctl
);
    // Select the actions of the current step.
    always_comb begin
        ctl        = '0;
        ctl.rf_sel = RF_ST;
        ctl.wsrc   = WSRC_ZERO;
        ctl.asel   = ASEL_VLO;
        if (cnt == CNT_W'(STEP_ST)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_ST;
            ctl.wsrc   = WSRC_ST;
        end else if (cnt == CNT_W'(STEP_SP)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_SP;
            ctl.wsrc   = WSRC_SP;
        end else if (cnt == CNT_W'(STEP_A)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_A;
        end else if (cnt == CNT_W'(STEP_B)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_B;
        end else if (cnt == CNT_W'(STEP_RD_LO)) begin
            ctl.rd   = 1'b1;
            ctl.asel = ASEL_VLO;
        end else if (cnt == CNT_W'(STEP_CAP_LO)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_PCL;
            ctl.wsrc   = WSRC_MEM;
            ctl.cap_lo = 1'b1;
        end else if (cnt == CNT_W'(STEP_RD_HI)) begin
            ctl.rd   = 1'b1;
            ctl.asel = ASEL_VHI;
        end else if (cnt == CNT_W'(STEP_CAP_HI)) begin
            ctl.rf_we  = 1'b1;
            ctl.rf_sel = RF_PCH;
            ctl.wsrc   = WSRC_MEM;
            ctl.cap_hi = 1'b1;
        end else if (cnt == CNT_W'(START_CYCLES)) begin
            ctl.rd    = 1'b1;
            ctl.asel  = ASEL_PC;
            ctl.fetch = 1'b1;
        end
    end

endmodule

// File: rtl/bvs_vector_latch.sv
// Holds the two program counter bytes taken from the memory return data.
// Assumes at most one capture strobe per cycle.
module bvs_vector_latch #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [DATA_W-1:0] rdata,
    output logic [PC_W-1:0]   pc
);
    localparam int LANES = PC_W / DATA_W;

    logic [LANES-1:0] cap;
    assign cap = {cap_hi, cap_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;

        // Take this byte lane on its capture strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap[g]) begin
                lane_q <= rdata;
            end
        end

        assign pc[g*DATA_W +: DATA_W] = lane_q;
    end

    // R5: the two capture strobes never coincide.
    p_cap_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_lo && cap_hi));

endmodule

// File: rtl/boot_vector_seq.sv
// Top of the boot vector sequencer. It runs the fixed post-reset schedule:
// register initial values, two vector byte reads and the first opcode fetch.
// Assumes memory read data arrives one cycle after the read strobe and
// that ADDR_W equals twice DATA_W.
module boot_vector_seq
    import bvs_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int START_CYCLES = 20,
    parameter int VEC_LO_ADDR  = 'h07FF,
    parameter int VEC_HI_ADDR  = 'h07FE,
    parameter int ST_INIT      = 'h00,
    parameter int SP_INIT      = 'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_sel,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              fetch_start
);
    localparam int CNT_W = $clog2(START_CYCLES + 2);
    localparam int PC_W  = 2 * DATA_W;

    logic [CNT_W-1:0] cnt;
    step_ctl_t        ctl;
    logic [PC_W-1:0]  pc_q;

    bvs_step_timer #(
        .START_CYCLES(START_CYCLES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt)
    );

    bvs_step_decode #(
        .START_CYCLES(START_CYCLES),
        .CNT_W       (CNT_W)
    ) u_decode (
        .cnt(cnt),
        .ctl(ctl)
    );

    bvs_vector_latch #(
        .DATA_W(DATA_W),
        .PC_W  (PC_W)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_lo(ctl.cap_lo),
        .cap_hi(ctl.cap_hi),
        .rdata (mem_rdata),
        .pc    (pc_q)
    );

    // Drive the read strobe and pick the address for this step.
    always_comb begin
        mem_rd   = ctl.rd;
        mem_addr = '0;
        if (ctl.rd) begin
            case (ctl.asel)
                ASEL_VLO: mem_addr = ADDR_W'(VEC_LO_ADDR);
                ASEL_VHI: mem_addr = ADDR_W'(VEC_HI_ADDR);
                default:  mem_addr = ADDR_W'(pc_q);
            endcase
        end
    end

    // Drive the register write port from the control word.
    always_comb begin
        rf_we  = ctl.rf_we;
        rf_sel = ctl.rf_sel;
        case (ctl.wsrc)
            WSRC_ST:  rf_wdata = DATA_W'(ST_INIT);
            WSRC_SP:  rf_wdata = DATA_W'(SP_INIT);
            WSRC_MEM: rf_wdata = mem_rdata;
            default:  rf_wdata = '0;
        endcase
    end

    assign fetch_start = ctl.fetch;

    // R1: the first cycle after release still shows the idle outputs of reset.
    p_idle_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_rd && !rf_we && !fetch_start));

    // R2: the stack pointer write comes right after the status write.
    p_sp_after_st_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_sel == 3'(RF_SP)) |-> $past(rf_we && rf_sel == 3'(RF_ST)));

    // R4: a PC low byte write is always the cycle after the low vector read.
    p_pcl_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_sel == 3'(RF_PCL)) |->
            $past(mem_rd && mem_addr == ADDR_W'(VEC_LO_ADDR)));

    // R5: the high byte is written two cycles after the low byte.
    p_pch_after_pcl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_sel == 3'(RF_PCH)) |-> $past(rf_we && rf_sel == 3'(RF_PCL), 2));

    // R6: the fetch marker is a one-cycle pulse carrying a read.
    p_fetch_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> mem_rd ##1 !fetch_start);

    // R7: nothing is driven after the fetch cycle.
    p_quiet_after_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> (!mem_rd && !rf_we && !fetch_start));

endmodule

// File: tb/tb_boot_vector_seq.sv
// Self-checking bench: sweeps vector byte pairs and abort points, and
// compares every cycle with the schedule computed here.
module tb_boot_vector_seq;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int START  = 20;
    localparam int TAIL   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = 8'h00;
    logic              rf_we;
    logic [2:0]        rf_sel;
    logic [DATA_W-1:0] rf_wdata;
    logic              fetch_start;

    int checks = 0;
    int fails  = 0;
    logic [7:0] vec_lo = 8'h00;
    logic [7:0] vec_hi = 8'h00;
    logic [7:0] junk   = 8'hA5;

    always #4 clk = ~clk;

    boot_vector_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .rf_we      (rf_we),
        .rf_sel     (rf_sel),
        .rf_wdata   (rf_wdata),
        .fetch_start(fetch_start)
    );

    // Memory model: data one cycle after the strobe, noise otherwise (R9).
    always @(posedge clk) begin
        junk <= {junk[6:0], junk[7] ^ junk[5] ^ junk[4] ^ junk[3]};
        if (mem_rd && mem_addr == 16'h07FF)      mem_rdata <= vec_lo;
        else if (mem_rd && mem_addr == 16'h07FE) mem_rdata <= vec_hi;
        else                                     mem_rdata <= junk;
    end

    // Compare one cycle of the schedule (cycle n after release).
    task automatic check_cycle(input int n, input string ctx);
        logic       e_we, e_rd, e_fetch, bad;
        logic [2:0] e_sel;
        logic [7:0] e_wd;
        logic [15:0] e_addr;
        string      req;
        e_we = 1'b0; e_rd = 1'b0; e_fetch = 1'b0;
        e_sel = 3'd0; e_wd = 8'h00; e_addr = 16'h0000;
        case (n)
            1: begin e_we = 1'b1; e_sel = 3'd0; e_wd = 8'h00; req = "R2"; end
            2: begin e_we = 1'b1; e_sel = 3'd1; e_wd = 8'h01; req = "R2"; end
            3: begin e_we = 1'b1; e_sel = 3'd2; e_wd = 8'h00; req = "R3"; end
            4: begin e_we = 1'b1; e_sel = 3'd3; e_wd = 8'h00; req = "R3"; end
            5: begin e_rd = 1'b1; e_addr = 16'h07FF; req = "R4"; end
            6: begin e_we = 1'b1; e_sel = 3'd4; e_wd = vec_lo; req = "R5 R9"; end
            7: begin e_rd = 1'b1; e_addr = 16'h07FE; req = "R4"; end
            8: begin e_we = 1'b1; e_sel = 3'd5; e_wd = vec_hi; req = "R5 R9"; end
            START: begin
                e_rd = 1'b1; e_fetch = 1'b1; e_addr = {vec_hi, vec_lo};
                req = "R6 R9";
            end
            default: req = (n > START) ? "R7" : "R3 R4";
        endcase
        bad = (rf_we !== e_we) || (mem_rd !== e_rd) || (fetch_start !== e_fetch);
        if (e_we && (rf_sel !== e_sel || rf_wdata !== e_wd)) bad = 1'b1;
        if (e_rd && mem_addr !== e_addr) bad = 1'b1;
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s %s cycle %0d: we=%b sel=%0d wd=%h rd=%b addr=%h fetch=%b expected we=%b sel=%0d wd=%h rd=%b addr=%h fetch=%b",
                     req, ctx, n, rf_we, rf_sel, rf_wdata, mem_rd, mem_addr, fetch_start,
                     e_we, e_sel, e_wd, e_rd, e_addr, e_fetch);
        end
    endtask

    // Outputs must be quiet while reset is held (R1, R8).
    task automatic check_idle(input string req);
        checks++;
        if (rf_we !== 1'b0 || mem_rd !== 1'b0 || fetch_start !== 1'b0) begin
            fails++;
            $display("FAIL %s reset idle: we=%b rd=%b fetch=%b expected we=0 rd=0 fetch=0",
                     req, rf_we, mem_rd, fetch_start);
        end
    endtask

    // Hold reset for a number of cycles, then release at a falling edge.
    task automatic do_reset(input int cycles, input string req);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_idle(req);
        end
        rst_n = 1'b1;
    endtask

    // Full schedule from release to a few cycles past the fetch.
    task automatic run_full(input logic [7:0] lo, input logic [7:0] hi, input string ctx);
        vec_lo = lo;
        vec_hi = hi;
        do_reset(2, "R1");
        for (int n = 1; n <= START + TAIL; n++) begin
            @(negedge clk);
            check_cycle(n, ctx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        // R1: idle state during the initial reset.
        repeat (3) @(negedge clk);
        check_idle("R1");

        // Vector byte sweep: low and high bytes varied independently.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run_full(8'(i * 17), 8'((j * 16) + (15 - j)), "sweep");
            end
        end

        // R8: abort after every possible cycle count, restart with new bytes.
        for (int k = 1; k <= START + 2; k++) begin
            vec_lo = 8'(k * 29 + 3);
            vec_hi = 8'(k * 13 + 7);
            do_reset(2, "R1");
            for (int n = 1; n <= k; n++) begin
                @(negedge clk);
                check_cycle(n, "R8 before abort");
            end
            vec_lo = 8'(~(k * 29 + 3));
            vec_hi = 8'(k * 41 + 90);
            do_reset(1 + (k % 3), "R8");
            for (int n = 1; n <= START + TAIL; n++) begin
                @(negedge clk);
                check_cycle(n, "R8 restart");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule